// File: doc/BRIEF.md
# Video Sync Alignment and Polarity Stage

This block sits beside a fixed-latency pixel pipeline and delays the active-low horizontal sync, vertical sync and blanking inputs by the same number of pixel clocks as the pixel data, so that all three line up with the pixels leaving the pipeline. The delayed signals are also driven out directly, for the converter stage that consumes them.

In normal display mode, each delayed sync output can be passed unchanged or inverted. One control bit per sync selects this. In pass-through mode the same sync inputs are forwarded with their original polarity, and the polarity bits have no effect. A mode-select output reports the current mode, so an external multiplexer can pick the board's sync source. A sync-off output tells the green channel to turn its sync current source off whenever either delayed sync is active. The blanking level does not affect it.

The block is a plain synchronous timing path. It has no handshake and no back-pressure. A value enters on every pixel clock and leaves a fixed number of clocks later. The polarity and mode pins act at the output without added delay. The register that drives the two polarity bits should reset them to 1, which gives active-low syncs by default.

Top module: `sync_align`

## Requirements
- R1: The delayed sync and blank outputs (`hsync_dly_n`, `vsync_dly_n`, `blank_dly_n`) equal the corresponding inputs sampled exactly DEPTH rising clock edges earlier. The default DEPTH is 3, and all three signals share that depth.
- R2: While reset is held, and for the first DEPTH clock edges after its release, all three delayed outputs are 1 (inactive).
- R3: In normal mode (`normal_mode` = 1), a polarity bit of 1 makes `hsync_out`/`vsync_out` equal the delayed sync unchanged (active low).
- R4: In normal mode, a polarity bit of 0 makes `hsync_out`/`vsync_out` the bitwise inverse of the delayed sync.
- R5: In pass-through mode (`normal_mode` = 0), `hsync_out`/`vsync_out` equal the delayed syncs whatever the polarity bits hold.
- R6: `mux_sel` is 1 in normal mode and 0 in pass-through mode, and it follows `normal_mode` in the same cycle.
- R7: `sync_off` is 1 exactly when `hsync_dly_n` or `vsync_dly_n` is 0, independent of `blank_dly_n` and of mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| blank_n | input | 1 | Blanking, active low |
| normal_mode | input | 1 | 1 = normal display mode, 0 = pass-through mode |
| hpol | input | 1 | Horizontal output polarity: 1 keeps, 0 inverts (normal mode only) |
| vpol | input | 1 | Vertical output polarity: 1 keeps, 0 inverts (normal mode only) |
| hsync_dly_n | output | 1 | Horizontal sync delayed by DEPTH clocks |
| vsync_dly_n | output | 1 | Vertical sync delayed by DEPTH clocks |
| blank_dly_n | output | 1 | Blanking delayed by DEPTH clocks |
| hsync_out | output | 1 | Horizontal sync after the mode-dependent polarity |
| vsync_out | output | 1 | Vertical sync after the mode-dependent polarity |
| mux_sel | output | 1 | Mode indication for an external sync multiplexer |
| sync_off | output | 1 | 1 turns off the green-channel sync current |

## Verification
On every cycle, the assertions check the polarity rules in each mode, the bypass of the polarity bits in pass-through mode, and the rule that an active delayed sync forces the sync-off control, including while blanking is inactive. They also use a cycle counter to check that the delayed outputs stay inactive during the fill window after reset. The exact DEPTH-clock latency on each of the three signals is shown only by the bench's sweep. That sweep drives a varied pattern through every combination of mode and polarity bits and compares each output against the input history.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
  typedef struct packed {
    logic hs_n;
    logic vs_n;
    logic bl_n;
  } vctl_t;

  localparam vctl_t VCTL_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, bl_n: 1'b1};
endpackage

// File: rtl/sync_delay_line.sv
module sync_delay_line
  import vsp_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  vctl_t din,
  output vctl_t dout
);
  vctl_t stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= VCTL_IDLE;
        else        stg[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= VCTL_IDLE;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/sync_polarity.sv
module sync_polarity (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_dly_n,
  input  logic normal_mode,
  input  logic keep_pol,
  output logic sync_q
);
  logic invert;

  assign invert = normal_mode & ~keep_pol;
  assign sync_q = sync_dly_n ^ invert;

  // R5
  bypass_in_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !normal_mode |-> (sync_q == sync_dly_n));
  // R4
  invert_in_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (normal_mode && !keep_pol) |-> (sync_q != sync_dly_n));
endmodule

// File: rtl/sync_align.sv
module sync_align
  import vsp_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_n,
  input  logic vsync_n,
  input  logic blank_n,
  input  logic normal_mode,
  input  logic hpol,
  input  logic vpol,
  output logic hsync_dly_n,
  output logic vsync_dly_n,
  output logic blank_dly_n,
  output logic hsync_out,
  output logic vsync_out,
  output logic mux_sel,
  output logic sync_off
);
  localparam int CW = $clog2(DEPTH + 1) + 1;

  vctl_t ctl_in, ctl_dly;

  assign ctl_in = '{hs_n: hsync_n, vs_n: vsync_n, bl_n: blank_n};

  sync_delay_line #(.DEPTH(DEPTH)) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ctl_in),
    .dout (ctl_dly)
  );

  assign hsync_dly_n = ctl_dly.hs_n;
  assign vsync_dly_n = ctl_dly.vs_n;
  assign blank_dly_n = ctl_dly.bl_n;

  sync_polarity u_hpol (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_dly_n (ctl_dly.hs_n),
    .normal_mode(normal_mode),
    .keep_pol   (hpol),
    .sync_q     (hsync_out)
  );

  sync_polarity u_vpol (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_dly_n (ctl_dly.vs_n),
    .normal_mode(normal_mode),
    .keep_pol   (vpol),
    .sync_q     (vsync_out)
  );

  assign mux_sel  = normal_mode;
  assign sync_off = ~(ctl_dly.hs_n & ctl_dly.vs_n);

  // Edges since reset release, saturating at DEPTH; used only by checks.
  logic [CW-1:0] fill_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         fill_cnt <= '0;
    else if (fill_cnt != CW'(DEPTH))    fill_cnt <= fill_cnt + 1'b1;
  end

  // R2
  idle_during_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt != CW'(DEPTH)) |-> (hsync_dly_n && vsync_dly_n && blank_dly_n));
  // R3
  keep_in_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (normal_mode && hpol) |-> (hsync_out == hsync_dly_n));
  // R7
  off_while_unblanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_dly_n && !(hsync_dly_n && vsync_dly_n)) |-> sync_off);
  // R7
  on_when_syncs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync_dly_n && vsync_dly_n) |-> !sync_off);
endmodule

// File: tb/sync_align_test.sv
module sync_align_test;
  localparam int DEPTH = 3;
  localparam int NCYC  = 200;

  logic clk = 1'b0;
  logic rst_n;
  logic hsync_n, vsync_n, blank_n, normal_mode, hpol, vpol;
  logic hsync_dly_n, vsync_dly_n, blank_dly_n, hsync_out, vsync_out, mux_sel, sync_off;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [2:0] hist [NCYC];

  always #2 clk = ~clk;

  sync_align #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .blank_n(blank_n),
    .normal_mode(normal_mode), .hpol(hpol), .vpol(vpol),
    .hsync_dly_n(hsync_dly_n), .vsync_dly_n(vsync_dly_n), .blank_dly_n(blank_dly_n),
    .hsync_out(hsync_out), .vsync_out(vsync_out),
    .mux_sel(mux_sel), .sync_off(sync_off)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [2:0] d;
    logic eh, ev;
    rst_n = 1'b0;
    hsync_n = 1'b0; vsync_n = 1'b0; blank_n = 1'b0;
    normal_mode = 1'b1; hpol = 1'b1; vpol = 1'b1;
    repeat (4) @(negedge clk);
    // R2: reset state
    chk("R2", "hsync_dly_n in reset", hsync_dly_n, 1'b1);
    chk("R2", "vsync_dly_n in reset", vsync_dly_n, 1'b1);
    chk("R2", "blank_dly_n in reset", blank_dly_n, 1'b1);
    chk("R7", "sync_off in reset", sync_off, 1'b0);
    chk("R6", "mux_sel normal", mux_sel, 1'b1);

    for (int t = 0; t < NCYC; t++) begin
      if (t > 0) begin
        d = (t >= DEPTH) ? hist[t-DEPTH] : 3'b111;
        // d = {hs, vs, bl}
        // R1 / R2: latency and fill
        chk((t >= DEPTH) ? "R1" : "R2", "hsync_dly_n", hsync_dly_n, d[2]);
        chk((t >= DEPTH) ? "R1" : "R2", "vsync_dly_n", vsync_dly_n, d[1]);
        chk((t >= DEPTH) ? "R1" : "R2", "blank_dly_n", blank_dly_n, d[0]);
        eh = normal_mode ? (d[2] ^ ~hpol) : d[2];
        ev = normal_mode ? (d[1] ^ ~vpol) : d[1];
        chk(!normal_mode ? "R5" : (hpol ? "R3" : "R4"), "hsync_out", hsync_out, eh);
        chk(!normal_mode ? "R5" : (vpol ? "R3" : "R4"), "vsync_out", vsync_out, ev);
        // R6
        chk("R6", "mux_sel", mux_sel, normal_mode);
        // R7: independent of blank level
        chk("R7", "sync_off", sync_off, ~(d[2] & d[1]));
      end
      hist[t] = 3'((t * 3 + t / 7) % 8);
      {hsync_n, vsync_n, blank_n} = hist[t];
      {normal_mode, hpol, vpol} = 3'(((t / 24) + 4) % 8);
      rst_n = 1'b1;
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule